// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Bank

This block controls a group of eight general-purpose pads through four word-wide registers reached over a simple synchronous read/write port. For each pin, software picks a 4-bit function code, an output data bit, a 2-bit pull mode, a 2-bit drive strength and a slew-rate bit. The block turns these fields into the pad controls: output enable, output level, pull-up and pull-down enables, drive-strength code and slew select. A global pin number maps to a pin of this bank as the number modulo eight.

Only two function codes have a meaning. Code 0x0 makes the pin an input and code 0x1 makes it an output. Every other code leaves the pad undriven and treats the pin as an input. When the data register is read, an input pin returns its pad level after a two-flop synchronizer, and an output pin returns the level it was last written.

The word index in address bits [3:2] selects the register: 0 is function, 1 is data, 2 is pull, 3 is drive/slew. Bits [1:0] of the address are ignored. Read data is registered and appears the cycle after the request.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, all four registers read zero. Every pin is an input with no pull, drive code 0 (1x) and slew 0, so pad_oe, pad_out, pad_pu_en, pad_pd_en, pad_drv and pad_slew are all zero.
- R2: Pin n's function code sits in function-register bits [4n+3:4n]. pad_oe[n] is 1 only for code 0x1. Code 0x0 and every other code give pad_oe[n]=0. The register reads back exactly as written.
- R3: Bit n of a data-register write sets pad_out[n]. The stored bit drives pad_out whatever the pin's function code.
- R4: When the data register is read, bit n returns the stored output bit if pin n's code is 0x1. Otherwise it returns pad_in[n] through two synchronizing flops. A pad change made just before a read clock edge shows up in the read captured at the third edge, and not in the reads captured at the first and second edges.
- R5: Pin n's pull code sits in pull-register bits [2n+1:2n]. Code 2'b11 sets only pad_pu_en[n]. Code 2'b01 sets only pad_pd_en[n]. Codes 2'b00 and 2'b10 clear both.
- R6: Pin n's drive code sits in drive-register bits [2n+1:2n] and appears on pad_drv[2n+1:2n]. Codes 0 to 3 mean 1x to 4x.
- R7: Pin n's slew bit sits at drive-register bit n+16 and appears on pad_slew[n].
- R8: A register changes only on a cycle with bus_sel=1 and bus_wr=1, and its new value shows on the pad outputs after that clock edge. bus_rdata changes only at the edge that follows a read request (bus_sel=1, bus_wr=0). At every other edge it keeps its value.
- R9: Bits that no field occupies are dropped on write and read as zero. These are data bits [31:8], pull bits [31:16] and drive bits [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output level per pin |
| pad_pu_en | output | 8 | Pull-up enable per pin |
| pad_pd_en | output | 8 | Pull-down enable per pin |
| pad_drv | output | 16 | Drive-strength code, two bits per pin |
| pad_slew | output | 8 | Slew select per pin |

## Verification
The assertions take bus_sel, bus_wr and bus_addr to be known values at every clock edge while reset is released, and rst_n to be low from time zero until the first edges have passed. Pad inputs may change at any time, because nothing checked by a property depends on their timing. The bench drives every bus signal on the falling edge, so it holds the bus idle during reset and never leaves a control line undefined. It changes pad_in only on falling edges, so the synchronizer delay can be counted in whole cycles.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and types for the GPIO bank.
// Assumes a 32-bit bus word and at most 8 pins, so slew bits fit in [23:16].
package gpio_bank_pkg;
    localparam int GB_PINS   = 8;
    localparam int GB_FUNC_W = 4;
    localparam int GB_PULL_W = 2;
    localparam int GB_DRV_W  = 2;
    localparam int GB_SLEW_LSB = 16;
    localparam int GB_BUS_W  = 32;
    localparam int GB_ADDR_W = 4;

    typedef enum logic [1:0] {
        REG_FUNC = 2'd0,
        REG_DATA = 2'd1,
        REG_PULL = 2'd2,
        REG_DRIVE = 2'd3
    } gb_reg_e;

    localparam logic [GB_FUNC_W-1:0] FN_INPUT  = 4'h0;
    localparam logic [GB_FUNC_W-1:0] FN_OUTPUT = 4'h1;
    localparam logic [GB_PULL_W-1:0] PULL_DOWN = 2'b01;
    localparam logic [GB_PULL_W-1:0] PULL_UP   = 2'b11;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the asynchronous pad inputs.
// Assumes each bit is an independent level, so no bus coherency is needed.
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the pad levels through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Per-pin decode: turns one pin's fields into pad controls and its data read bit.
// Assumes function codes other than output mean "hold as input".
module gpio_pin_ctrl
    import gpio_bank_pkg::*;
(
    input  logic [GB_FUNC_W-1:0] func_code,
    input  logic                 out_bit,
    input  logic [GB_PULL_W-1:0] pull_code,
    input  logic [GB_DRV_W-1:0]  drv_code,
    input  logic                 slew_bit,
    input  logic                 pad_sync,
    output logic                 oe,
    output logic                 out_lvl,
    output logic                 pu_en,
    output logic                 pd_en,
    output logic [GB_DRV_W-1:0]  drv,
    output logic                 slew,
    output logic                 rd_bit
);
    // Decode direction, pulls and the data read source for this pin.
    always_comb begin
        oe      = (func_code == FN_OUTPUT);
        out_lvl = out_bit;
        pu_en   = (pull_code == PULL_UP);
        pd_en   = (pull_code == PULL_DOWN);
        drv     = drv_code;
        slew    = slew_bit;
        rd_bit  = oe ? out_bit : pad_sync;
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Register file for the GPIO bank: write decode, storage and registered read mux.
// Assumes one access per cycle; address bits [1:0] are ignored.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = GB_PINS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [GB_ADDR_W-1:0]          bus_addr,
    input  logic [GB_BUS_W-1:0]           bus_wdata,
    input  logic [NUM_PINS-1:0]           data_view,
    output logic [GB_BUS_W-1:0]           bus_rdata,
    output logic [NUM_PINS*GB_FUNC_W-1:0] func_q,
    output logic [NUM_PINS-1:0]           data_q,
    output logic [NUM_PINS*GB_PULL_W-1:0] pull_q,
    output logic [NUM_PINS*GB_DRV_W-1:0]  drv_q,
    output logic [NUM_PINS-1:0]           slew_q
);
    localparam int FUNC_BITS = NUM_PINS * GB_FUNC_W;
    localparam int PULL_BITS = NUM_PINS * GB_PULL_W;
    localparam int DRV_BITS  = NUM_PINS * GB_DRV_W;

    gb_reg_e reg_idx;
    logic    wr_en;
    logic    rd_en;
    logic [GB_BUS_W-1:0] rd_word;
    logic    unused_addr_lsb;

    assign reg_idx = gb_reg_e'(bus_addr[3:2]);
    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && !bus_wr;
    assign unused_addr_lsb = ^bus_addr[1:0];

    // Update the function-select register on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
        end else if (wr_en && reg_idx == REG_FUNC) begin
            func_q <= bus_wdata[FUNC_BITS-1:0];
        end
    end

    // Update the output data register on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_en && reg_idx == REG_DATA) begin
            data_q <= bus_wdata[NUM_PINS-1:0];
        end
    end

    // Update the pull register on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q <= '0;
        end else if (wr_en && reg_idx == REG_PULL) begin
            pull_q <= bus_wdata[PULL_BITS-1:0];
        end
    end

    // Update drive codes and slew bits on a drive-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q  <= '0;
            slew_q <= '0;
        end else if (wr_en && reg_idx == REG_DRIVE) begin
            drv_q  <= bus_wdata[DRV_BITS-1:0];
            slew_q <= bus_wdata[GB_SLEW_LSB +: NUM_PINS];
        end
    end

    // Assemble the selected register word with unoccupied bits at zero.
    always_comb begin
        rd_word = '0;
        case (reg_idx)
            REG_FUNC:  rd_word[FUNC_BITS-1:0] = func_q;
            REG_DATA:  rd_word[NUM_PINS-1:0]  = data_view;
            REG_PULL:  rd_word[PULL_BITS-1:0] = pull_q;
            REG_DRIVE: begin
                rd_word[DRV_BITS-1:0]              = drv_q;
                rd_word[GB_SLEW_LSB +: NUM_PINS]   = slew_q;
            end
            default:   rd_word = '0;
        endcase
    end

    // Capture read data only when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Top of the eight-pin GPIO bank: registers, input synchronizer and per-pin decode.
// Assumes pad_in is asynchronous and every bus input is synchronous to clk.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = GB_PINS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [GB_ADDR_W-1:0]         bus_addr,
    input  logic [GB_BUS_W-1:0]          bus_wdata,
    output logic [GB_BUS_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]          pad_in,
    output logic [NUM_PINS-1:0]          pad_oe,
    output logic [NUM_PINS-1:0]          pad_out,
    output logic [NUM_PINS-1:0]          pad_pu_en,
    output logic [NUM_PINS-1:0]          pad_pd_en,
    output logic [NUM_PINS*GB_DRV_W-1:0] pad_drv,
    output logic [NUM_PINS-1:0]          pad_slew
);
    logic [NUM_PINS*GB_FUNC_W-1:0] func_q;
    logic [NUM_PINS-1:0]           data_q;
    logic [NUM_PINS*GB_PULL_W-1:0] pull_q;
    logic [NUM_PINS*GB_DRV_W-1:0]  drv_q;
    logic [NUM_PINS-1:0]           slew_q;
    logic [NUM_PINS-1:0]           pad_sync;
    logic [NUM_PINS-1:0]           data_view;

    gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .data_view (data_view),
        .bus_rdata (bus_rdata),
        .func_q    (func_q),
        .data_q    (data_q),
        .pull_q    (pull_q),
        .drv_q     (drv_q),
        .slew_q    (slew_q)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_ctrl u_pin (
            .func_code (func_q[p*GB_FUNC_W +: GB_FUNC_W]),
            .out_bit   (data_q[p]),
            .pull_code (pull_q[p*GB_PULL_W +: GB_PULL_W]),
            .drv_code  (drv_q[p*GB_DRV_W +: GB_DRV_W]),
            .slew_bit  (slew_q[p]),
            .pad_sync  (pad_sync[p]),
            .oe        (pad_oe[p]),
            .out_lvl   (pad_out[p]),
            .pu_en     (pad_pu_en[p]),
            .pd_en     (pad_pd_en[p]),
            .drv       (pad_drv[p*GB_DRV_W +: GB_DRV_W]),
            .slew      (pad_slew[p]),
            .rd_bit    (data_view[p])
        );
    end
endmodule

// File: rtl/gpio_bank_checker.sv
// Property checker for the GPIO bank, bound to every instance of the top.
// Assumes rst_n is low from time zero and bus controls are known out of reset.
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = GB_PINS
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_sel,
    input logic                         bus_wr,
    input logic [GB_ADDR_W-1:0]         bus_addr,
    input logic [GB_BUS_W-1:0]          bus_wdata,
    input logic [GB_BUS_W-1:0]          bus_rdata,
    input logic [NUM_PINS-1:0]          pad_oe,
    input logic [NUM_PINS-1:0]          pad_out,
    input logic [NUM_PINS-1:0]          pad_pu_en,
    input logic [NUM_PINS-1:0]          pad_pd_en,
    input logic [NUM_PINS*GB_DRV_W-1:0] pad_drv,
    input logic [NUM_PINS-1:0]          pad_slew
);
    logic wr_func, wr_data, wr_drive, rd_data, rd_req;
    assign wr_func  = bus_sel && bus_wr && bus_addr[3:2] == 2'd0;
    assign wr_data  = bus_sel && bus_wr && bus_addr[3:2] == 2'd1;
    assign wr_drive = bus_sel && bus_wr && bus_addr[3:2] == 2'd3;
    assign rd_data  = bus_sel && !bus_wr && bus_addr[3:2] == 2'd1;
    assign rd_req   = bus_sel && !bus_wr;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pu_en == '0 &&
                          pad_pd_en == '0 && pad_drv == '0 && pad_slew == '0 &&
                          bus_rdata == '0));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
        p_func_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_func |=> (pad_oe[p] == ($past(bus_wdata[p*GB_FUNC_W +: GB_FUNC_W]) == FN_OUTPUT)));
    end

    p_data_to_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (pad_out == $past(bus_wdata[NUM_PINS-1:0])));

    p_pull_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_en & pad_pd_en) == '0);

    p_drive_to_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drive |=> (pad_drv == $past(bus_wdata[NUM_PINS*GB_DRV_W-1:0])));

    p_slew_to_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drive |=> (pad_slew == $past(bus_wdata[GB_SLEW_LSB +: NUM_PINS])));

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata));

    p_oe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_func |=> $stable(pad_oe));

    p_data_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data |=> (bus_rdata[GB_BUS_W-1:NUM_PINS] == '0));
endmodule

bind gpio_bank gpio_bank_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu_en (pad_pu_en),
    .pad_pd_en (pad_pd_en),
    .pad_drv   (pad_drv),
    .pad_slew  (pad_slew)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
// Directed bench for the GPIO bank: one task per scenario, each checking itself.
module gpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe, pad_out, pad_pu_en, pad_pd_en, pad_slew;
    logic [15:0] pad_drv;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en), .pad_drv(pad_drv),
        .pad_slew(pad_slew)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pad_oe", {24'd0, pad_oe}, 32'd0);
        check("R1 pad_out", {24'd0, pad_out}, 32'd0);
        check("R1 pulls", {16'd0, pad_pu_en, pad_pd_en}, 32'd0);
        check("R1 drive/slew", {8'd0, pad_slew, pad_drv}, 32'd0);
        for (int r = 0; r < 4; r++) begin
            bus_read(4'(r * 4), d);
            check("R1 register reset value", d, 32'd0);
        end
    endtask

    task automatic t_function();
        logic [31:0] d;
        // pins 7..0 codes 1,0,1,F,1,2,0,1 -> outputs on pins 0,3,5,7
        bus_write(4'h0, 32'h101F_1201);
        check("R2 pad_oe from codes", {24'd0, pad_oe}, 32'h0000_00A9);
        bus_read(4'h2, d); // address bits [1:0] ignored
        check("R2 function readback", d, 32'h101F_1201);
    endtask

    task automatic t_output_and_sync();
        logic [31:0] d;
        bus_write(4'h4, 32'hFFFF_FF5A);
        check("R3 pad_out follows data", {24'd0, pad_out}, 32'h0000_005A);
        bus_read(4'h4, d);
        check("R4/R9 data read, pads low", d, 32'h0000_0008);
        // raise all pads together with a read request
        @(negedge clk);
        pad_in = 8'hFF; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4;
        @(negedge clk);
        check("R4 first edge still old", bus_rdata, 32'h0000_0008);
        @(negedge clk);
        check("R4 second edge still old", bus_rdata, 32'h0000_0008);
        @(negedge clk);
        check("R4 third edge shows pads", bus_rdata, 32'h0000_005E);
        bus_sel = 1'b0;
    endtask

    task automatic t_pull();
        logic [31:0] d;
        // pins 0..7 codes 0,1,2,3,3,2,1,0
        bus_write(4'h8, 32'hFFFF_1BE4);
        check("R5 pull-up enables", {24'd0, pad_pu_en}, 32'h0000_0018);
        check("R5 pull-down enables", {24'd0, pad_pd_en}, 32'h0000_0042);
        bus_read(4'h8, d);
        check("R9 pull readback upper zero", d, 32'h0000_1BE4);
    endtask

    task automatic t_drive();
        logic [31:0] d;
        bus_write(4'hC, 32'hFFC3_1B2D);
        check("R6 drive codes", {16'd0, pad_drv}, 32'h0000_1B2D);
        check("R7 slew bits", {24'd0, pad_slew}, 32'h0000_00C3);
        bus_read(4'hC, d);
        check("R7/R9 drive readback", d, 32'h00C3_1B2D);
    endtask

    task automatic t_idle();
        logic [31:0] d;
        // write controls active but no select: nothing may change
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0000_0000;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 unselected write ignored", {24'd0, pad_oe}, 32'h0000_00A9);
        check("R8 rdata held with no read", bus_rdata, 32'h00C3_1B2D);
        bus_write(4'h4, 32'h0000_0000);
        check("R8 rdata held across write", bus_rdata, 32'h00C3_1B2D);
        check("R3 pad_out cleared", {24'd0, pad_out}, 32'h0000_0000);
        bus_read(4'h0, d);
        check("R8 function untouched", d, 32'h101F_1201);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_function();
        t_output_and_sync();
        t_pull();
        t_drive();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule